// File: doc/BRIEF.md
# Dual-Mode Hardware Stack Engine

This block runs push and pop operations for a 16-bit stack pointer against a byte-wide memory port. A request carries a direction (push or pop), an operand size (one byte or a 16-bit word) and, for a push, the data to store. The engine issues one memory byte access per clock. For a word it issues two accesses, the lower address first. It then raises a one-cycle done pulse, updates the stack pointer and, for a pop, presents the value read.

A mode input picks the stack convention when a request is accepted. In next-available mode the pointer marks the first free byte: a push writes at or below the pointer and then moves it down, and a pop reads above it. In last-used mode the pointer marks the newest stored byte: a push moves the pointer down first and writes there, and a pop reads from the pointer upward. Words are held big-endian in both modes, with the high byte at the lower address. Software can load the pointer while the engine is idle and can always read it back.

Top module: `stack_engine`

## Requirements
- R1: During and right after reset, sp is 0, busy and done are low and mem_en is low.
- R2: Next-available byte push (mode_lu=0, op_pop=0, op_word=0): writes wr_data[7:0] at sp, then sp becomes sp-1.
- R3: Next-available word push: writes wr_data[15:8] at sp-1 and wr_data[7:0] at sp, then sp becomes sp-2.
- R4: Next-available pop (op_pop=1): reads from sp+1 (a byte, or a word occupying sp+1 and sp+2), then sp grows by the operand size.
- R5: Last-used push (mode_lu=1): sp drops by the operand size, the operand is written starting at the new sp, and sp stays there.
- R6: Last-used pop: reads starting at sp itself, then sp grows by the operand size.
- R7: Each memory access lasts one clock, with mem_en high and mem_we high only for a push. A word uses two accesses to consecutive addresses, high byte at the lower address and lower address first. done pulses for one cycle right after the last access. A popped byte appears on rd_data as {8'h00, byte} and a popped word as {high, low} while done is high.
- R8: All pointer and address arithmetic wraps modulo 2^16.
- R9: busy is high from the cycle after acceptance until done. A request that arrives while busy is high is ignored, and sp changes only when done pulses or when a load takes effect.
- R10: sp_load while idle sets sp to sp_load_val on the next cycle and takes priority over a request in the same cycle. That request is dropped. sp_load while busy is ignored.
- R11: mode_lu is sampled only when a request is accepted, so changing it during an operation has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_lu | input | 1 | 1 selects last-used convention, 0 next-available |
| req_valid | input | 1 | Request strobe, accepted when idle |
| op_pop | input | 1 | 1 pop, 0 push |
| op_word | input | 1 | 1 word, 0 byte |
| wr_data | input | 16 | Push data (byte push uses bits 7:0) |
| rd_data | output | 16 | Pop result, valid with done |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | AW | Value to load |
| sp | output | AW | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid during the access cycle |

## Verification
The bench builds the engine with its default 16-bit pointer width. That width makes the wrap from 0xFFFF to 0x0000 reachable by loading the pointer near either end and splitting a word across the boundary in both conventions. A behavioural model predicts, for every cycle, the access address, direction and byte, the done pulse, the popped value and the pointer. With this model the test also covers requests and loads dropped while busy, a load colliding with a request, and a mode change in the middle of an operation.

// File: rtl/stack_engine.sv
module stack_engine #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_lu,
  input  logic          req_valid,
  input  logic          op_pop,
  input  logic          op_word,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  output logic          done,
  output logic          busy,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_load_val,
  output logic [AW-1:0] sp,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_A0, S_A1} state_t;

  state_t        st;
  logic          k_pop, k_word;
  logic [AW-1:0] base, nsp, sp_q;
  logic [15:0]   wbuf, rd_q;
  logic [7:0]    hi_q;
  logic          done_q;

  logic          go;
  logic [AW-1:0] size, base_c, nsp_c;

  assign go     = (st == S_IDLE) && req_valid && !sp_load;
  assign size   = op_word ? AW'(2) : AW'(1);
  assign nsp_c  = op_pop ? sp_q + size : sp_q - size;
  always_comb begin
    if (mode_lu)     base_c = op_pop ? sp_q : sp_q - size;
    else if (op_pop) base_c = sp_q + AW'(1);
    else             base_c = op_word ? sp_q - AW'(1) : sp_q;
  end

  assign busy      = (st != S_IDLE);
  assign mem_en    = busy;
  assign mem_we    = busy && !k_pop;
  assign mem_addr  = (st == S_A1) ? base + AW'(1) : base;
  assign mem_wdata = (k_word && st == S_A0) ? wbuf[15:8] : wbuf[7:0];
  assign sp        = sp_q;
  assign done      = done_q;
  assign rd_data   = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      k_pop  <= 1'b0;
      k_word <= 1'b0;
      base   <= '0;
      nsp    <= '0;
      sp_q   <= '0;
      wbuf   <= '0;
      rd_q   <= '0;
      hi_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sp_load) begin
            sp_q <= sp_load_val;
          end else if (go) begin
            k_pop  <= op_pop;
            k_word <= op_word;
            base   <= base_c;
            nsp    <= nsp_c;
            wbuf   <= wr_data;
            st     <= S_A0;
          end
        end
        S_A0: begin
          if (k_word) begin
            hi_q <= mem_rdata;
            st   <= S_A1;
          end else begin
            if (k_pop) rd_q <= {8'h00, mem_rdata};
            sp_q   <= nsp;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_A1: begin
          if (k_pop) rd_q <= {hi_q, mem_rdata};
          sp_q   <= nsp;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (done || $past(sp_load && !busy)));

  p_word_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(done)) |-> mem_addr == AW'($past(mem_addr) + AW'(1)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && !sp_load));

endmodule

// File: tb/test_stack_engine.sv
module test_stack_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_lu = 1'b0, req_valid = 1'b0, op_pop = 1'b0, op_word = 1'b0;
  logic [15:0] wr_data = '0, rd_data;
  logic        done, busy, sp_load = 1'b0;
  logic [15:0] sp_load_val = '0, sp;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  always #2 clk = ~clk;

  stack_engine #(.AW(16)) i_stack_engine (
    .clk(clk), .rst_n(rst_n), .mode_lu(mode_lu), .req_valid(req_valid),
    .op_pop(op_pop), .op_word(op_word), .wr_data(wr_data), .rd_data(rd_data),
    .done(done), .busy(busy), .sp_load(sp_load), .sp_load_val(sp_load_val),
    .sp(sp), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  int n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [7:0] dflt(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  logic [7:0] ram [int];
  logic [7:0] m_mem [int];

  function automatic logic [7:0] rd_ram(int a);
    return ram.exists(a) ? ram[a] : dflt(a);
  endfunction
  function automatic logic [7:0] rd_model(int a);
    return m_mem.exists(a) ? m_mem[a] : dflt(a);
  endfunction

  always @(posedge clk) if (mem_en && mem_we) ram[int'(mem_addr)] = mem_wdata;
  always @(negedge clk) mem_rdata <= rd_ram(int'(mem_addr));

  typedef struct {
    bit busy; bit en; bit we; int addr; int wd; bit done; int rd; bit chk_rd; int sp; string tag;
  } exp_t;
  exp_t  q[$];
  int    m_sp = 0;
  string tag_ovr = "";

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic exp_t idle_rec();
    exp_t e;
    e.busy = 0; e.en = 0; e.we = 0; e.addr = 0; e.wd = 0; e.done = 0;
    e.rd = 0; e.chk_rd = 0; e.sp = m_sp; e.tag = "R9";
    return e;
  endfunction

  always @(posedge clk) begin
    exp_t cur;
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_sp = 0;
    end else begin
      cur = (q.size() != 0) ? q[0] : idle_rec();
      if (q.size() != 0) void'(q.pop_front());
      if (!cur.busy) begin
        if (sp_load) begin
          m_sp = int'(sp_load_val);
        end else if (req_valid) begin
          int sz, base, nsp, old;
          string t;
          logic [7:0] b0, b1;
          exp_t e;
          sz = op_word ? 2 : 1;
          old = m_sp;
          if (mode_lu) begin
            base = op_pop ? old : (old - sz) & 16'hFFFF;
          end else begin
            base = op_pop ? (old + 1) & 16'hFFFF : (op_word ? (old - 1) & 16'hFFFF : old);
          end
          nsp = op_pop ? (old + sz) & 16'hFFFF : (old - sz) & 16'hFFFF;
          t = mode_lu ? (op_pop ? "R6" : "R5") : (op_pop ? "R4" : (op_word ? "R3" : "R2"));
          if (tag_ovr != "") t = tag_ovr;
          for (int i = 0; i < sz; i++) begin
            e = idle_rec();
            e.busy = 1; e.en = 1; e.we = !op_pop; e.sp = old; e.tag = t;
            e.addr = (base + i) & 16'hFFFF;
            e.wd = op_word ? (i == 0 ? int'(wr_data[15:8]) : int'(wr_data[7:0])) : int'(wr_data[7:0]);
            if (!op_pop) m_mem[e.addr] = 8'(e.wd);
            q.push_back(e);
          end
          b0 = rd_model(base);
          b1 = rd_model((base + 1) & 16'hFFFF);
          e = idle_rec();
          e.done = 1; e.sp = nsp; e.tag = t; e.chk_rd = op_pop;
          e.rd = op_word ? int'({b0, b1}) : int'({8'h00, b0});
          q.push_back(e);
          m_sp = nsp;
        end
      end
    end
  end

  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      e = (q.size() != 0) ? q[0] : idle_rec();
      chk("R9 busy", int'(busy), int'(e.busy));
      chk({e.tag, " R7 mem_en"}, int'(mem_en), int'(e.en));
      chk({e.tag, " R7 done"}, int'(done), int'(e.done));
      chk({e.tag, " sp"}, int'(sp), e.sp);
      if (e.en) begin
        chk({e.tag, " R7 mem_we"}, int'(mem_we), int'(e.we));
        chk({e.tag, " mem_addr"}, int'(mem_addr), e.addr);
        if (e.we) chk({e.tag, " R7 mem_wdata"}, int'(mem_wdata), e.wd);
      end
      if (e.chk_rd) chk({e.tag, " R7 rd_data"}, int'(rd_data), e.rd);
    end
  end

  task automatic op(bit lu, bit pop, bit word, logic [15:0] d);
    @(negedge clk);
    mode_lu = lu; op_pop = pop; op_word = word; wr_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic load(logic [15:0] v);
    @(negedge clk);
    sp_load = 1'b1; sp_load_val = v;
    @(negedge clk);
    sp_load = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 sp", int'(sp), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 mem_en", int'(mem_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp after release", int'(sp), 0);

    load(16'h1000);
    op(0, 0, 0, 16'h00AB);
    op(0, 0, 1, 16'hC3D4);
    op(0, 0, 0, 16'h0011);
    op(0, 1, 0, 0);
    op(0, 1, 1, 0);
    op(0, 1, 0, 0);
    op(0, 1, 1, 0);

    load(16'h2000);
    op(1, 0, 1, 16'hBEEF);
    op(1, 0, 0, 16'h0077);
    op(1, 1, 0, 0);
    op(1, 1, 1, 0);
    op(1, 1, 1, 0);

    tag_ovr = "R8";
    load(16'h0000);
    op(0, 0, 1, 16'h1234);
    op(0, 1, 1, 0);
    load(16'h0001);
    op(1, 0, 1, 16'h5678);
    op(1, 1, 1, 0);
    load(16'hFFFF);
    op(0, 1, 0, 0);

    tag_ovr = "R9";
    load(16'h3000);
    @(negedge clk);
    mode_lu = 0; op_pop = 0; op_word = 1; wr_data = 16'hA1B2; req_valid = 1'b1;
    @(negedge clk);
    mode_lu = 1; op_pop = 1; op_word = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    tag_ovr = "R10";
    @(negedge clk);
    op_pop = 0; op_word = 0; wr_data = 16'h00EE; req_valid = 1'b1;
    sp_load = 1'b1; sp_load_val = 16'h4000;
    @(negedge clk);
    req_valid = 1'b0; sp_load = 1'b0;
    @(negedge clk);
    chk("R10 load beats request", int'(sp), 16'h4000);
    chk("R10 request dropped", int'(busy), 0);
    @(negedge clk);
    mode_lu = 0; op_word = 1; wr_data = 16'h9988; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; sp_load = 1'b1; sp_load_val = 16'h5555;
    @(negedge clk);
    sp_load = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 load while busy ignored", int'(sp), 16'h3FFE);

    tag_ovr = "R11";
    @(negedge clk);
    mode_lu = 1; op_pop = 0; op_word = 1; wr_data = 16'h6A6B; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; mode_lu = 0;
    repeat (3) @(negedge clk);
    op(1, 1, 1, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule